// File: doc/BRIEF.md
# SMBus Host Register File

This block is the host-side register set of a system management bus controller, reached over a byte-wide I/O bus through a 16-byte address window. It holds six byte registers: status, control, command, slave address and two data bytes. It also holds a 32-byte block data buffer.

The block buffer is reached through a single data port. An internal index selects the buffer entry. Every access to the port advances the index, and the index wraps to the first entry after the last. Reading the control register rewinds the index, and so does writing the status register. Software can therefore stream a block through one address.

Two decode-enable inputs gate every access. When both are low, the block ignores the bus. The block does not drive the bus wires. It raises a one-cycle start pulse on each control write, so that an external transfer engine can begin a transaction.

Top module: `smb_host_regs`

## Requirements
- R1: Writes to offset 0x3 (command), 0x4 (slave address), 0x5 (data byte 0) and 0x6 (data byte 1) store the written byte. A read of the same offset returns that byte combinationally, in the cycle of the read strobe.
- R2: A write to offset 0x2 (control) stores the byte. A read of 0x2 returns only bits 4:0, with bits 7:5 read as zero, and the read rewinds the block index to 0.
- R3: An enabled write to offset 0x2 drives `start_pulse` high for exactly the one cycle after the write's clock edge.
- R4: Offset 0x7 is the block data port. A write stores the byte in the buffer entry at the index, and a read returns that entry. Either access then advances the index by one on the clock edge. The buffer has 32 entries.
- R5: An access to the block port at index 31 wraps the index to 0, so the 33rd access after a rewind reaches entry 0 again.
- R6: A write of any value to offset 0x0 (status) clears the status register and rewinds the block index to 0. The status register reads 0x00.
- R7: While both `dec_en_a` and `dec_en_b` are low, reads return 0xFF, and no read or write changes any register, the buffer or the index, or raises `start_pulse`. Either enable alone is enough to allow access.
- R8: Reads of the unused offsets 0x1 and 0x8 to 0xF return 0x00, and writes to them change nothing.
- R9: Reset clears all registers, the index, `start_pulse` and all 32 buffer entries to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_en_a | input | 1 | Access enable, first source |
| dec_en_b | input | 1 | Access enable, second source |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| start_pulse | output | 1 | One-cycle pulse after a control write |

## Verification
The index is hidden state, and an error in it shows only at the block data port. The bench catches it on the next read of 0x7: a missed increment, a wrong wrap or a missed rewind returns the byte of a neighbouring entry. Wrap errors show on the 33rd access after a rewind. A disabled access that leaks through shows on the next enabled read, as a changed register or a shifted block sequence. A start pulse that is stuck or too long is visible one cycle after the control write.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

    localparam int BYTE_W = 8;

    localparam logic [3:0] OFS_STATUS = 4'h0;
    localparam logic [3:0] OFS_CTRL   = 4'h2;
    localparam logic [3:0] OFS_CMD    = 4'h3;
    localparam logic [3:0] OFS_SLAVE  = 4'h4;
    localparam logic [3:0] OFS_DAT0   = 4'h5;
    localparam logic [3:0] OFS_DAT1   = 4'h6;
    localparam logic [3:0] OFS_BLK    = 4'h7;

    localparam int CTRL_RD_BITS = 5;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_CTRL,
        SEL_CMD,
        SEL_SLAVE,
        SEL_DAT0,
        SEL_DAT1,
        SEL_BLK
    } reg_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] status;
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] slave;
        logic [BYTE_W-1:0] dat0;
        logic [BYTE_W-1:0] dat1;
        logic              start;
    } host_regs_t;

endpackage

// File: rtl/smb_addr_dec.sv
module smb_addr_dec
    import smb_host_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_a,
    input  logic              en_b,
    input  logic              wr,
    input  logic              rd,
    output reg_sel_e          sel,
    output logic              acc_en,
    output logic              acc_wr,
    output logic              acc_rd
);

    always_comb begin
        acc_en = en_a | en_b;
        acc_wr = acc_en & wr;
        // a write in the same cycle takes precedence over read side effects
        acc_rd = acc_en & rd & ~wr;
    end

    always_comb begin
        sel = SEL_NONE;
        if (addr[ADDR_W-1:4] == '0 || ADDR_W == 4) begin
            unique case (addr[3:0])
                OFS_STATUS: sel = SEL_STATUS;
                OFS_CTRL:   sel = SEL_CTRL;
                OFS_CMD:    sel = SEL_CMD;
                OFS_SLAVE:  sel = SEL_SLAVE;
                OFS_DAT0:   sel = SEL_DAT0;
                OFS_DAT1:   sel = SEL_DAT1;
                OFS_BLK:    sel = SEL_BLK;
                default:    sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
    parameter int DEPTH  = 32,
    parameter int WIDTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_wr,
    input  logic             port_rd,
    input  logic             rewind,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] idx_d, idx_q;
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        idx_d = idx_q;
        if (port_wr) begin
            mem_d[idx_q] = wdata;
        end
        if (rewind) begin
            idx_d = '0;
        end else if (port_wr || port_rd) begin
            idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            idx_q <= idx_d;
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[idx_q];
    assign idx   = idx_q;

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int BUF_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_en_a,
    input  logic              dec_en_b,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              start_pulse
);

    localparam int IDX_W = $clog2(BUF_DEPTH);

    reg_sel_e          sel;
    logic              acc_en, acc_wr, acc_rd;
    logic              blk_wr, blk_rd, blk_rewind;
    logic [BYTE_W-1:0] blk_rdata;
    logic [IDX_W-1:0]  blk_idx;
    host_regs_t        regs_d, regs_q;

    smb_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .en_a   (dec_en_a),
        .en_b   (dec_en_b),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .sel    (sel),
        .acc_en (acc_en),
        .acc_wr (acc_wr),
        .acc_rd (acc_rd)
    );

    always_comb begin
        blk_wr     = acc_wr & (sel == SEL_BLK);
        blk_rd     = acc_rd & (sel == SEL_BLK);
        blk_rewind = (acc_wr & (sel == SEL_STATUS)) | (acc_rd & (sel == SEL_CTRL));
    end

    smb_blk_buf #(.DEPTH(BUF_DEPTH), .WIDTH(BYTE_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_wr (blk_wr),
        .port_rd (blk_rd),
        .rewind  (blk_rewind),
        .wdata   (bus_wdata),
        .rdata   (blk_rdata),
        .idx     (blk_idx)
    );

    // next-state for the byte registers
    always_comb begin
        regs_d       = regs_q;
        regs_d.start = 1'b0;
        if (acc_wr) begin
            unique case (sel)
                SEL_STATUS: regs_d.status = '0;
                SEL_CTRL: begin
                    regs_d.ctrl  = bus_wdata;
                    regs_d.start = 1'b1;
                end
                SEL_CMD:   regs_d.cmd   = bus_wdata;
                SEL_SLAVE: regs_d.slave = bus_wdata;
                SEL_DAT0:  regs_d.dat0  = bus_wdata;
                SEL_DAT1:  regs_d.dat1  = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // read mux, same-cycle return
    always_comb begin
        bus_rdata = '0;
        if (!acc_en) begin
            bus_rdata = '1;
        end else begin
            unique case (sel)
                SEL_STATUS: bus_rdata = regs_q.status;
                SEL_CTRL:   bus_rdata = {{(BYTE_W-CTRL_RD_BITS){1'b0}},
                                         regs_q.ctrl[CTRL_RD_BITS-1:0]};
                SEL_CMD:    bus_rdata = regs_q.cmd;
                SEL_SLAVE:  bus_rdata = regs_q.slave;
                SEL_DAT0:   bus_rdata = regs_q.dat0;
                SEL_DAT1:   bus_rdata = regs_q.dat1;
                SEL_BLK:    bus_rdata = blk_rdata;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign start_pulse = regs_q.start;

endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
    parameter int ADDR_W    = 4,
    parameter int BUF_DEPTH = 32,
    localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_a,
    input logic              en_b,
    input logic [ADDR_W-1:0] addr,
    input logic              wr,
    input logic              rd,
    input logic [7:0]        rdata,
    input logic              start,
    input logic [IDX_W-1:0]  idx
);

    logic en;
    logic blk_acc;
    logic unimpl;
    assign en      = en_a | en_b;
    assign blk_acc = en & (wr | rd) & (addr == ADDR_W'(7));
    assign unimpl  = (addr == ADDR_W'(1)) | (addr > ADDR_W'(7));

    // R7
    dis_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && rd) |-> rdata == 8'hFF);

    // R7
    dis_idx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(idx));

    // R3
    start_after_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr && addr == ADDR_W'(2)) |=> start);

    // R3
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(en && wr && addr == ADDR_W'(2)));

    // R2
    ctrl_read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rd && !wr && addr == ADDR_W'(2)) |-> rdata[7:5] == 3'b000);

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_acc && idx != IDX_W'(BUF_DEPTH - 1)) |=> idx == $past(idx) + 1'b1);

    // R5
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_acc && idx == IDX_W'(BUF_DEPTH - 1)) |=> idx == '0);

    // R8
    unimpl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rd && unimpl) |-> rdata == 8'h00);

endmodule

bind smb_host_regs smb_host_regs_chk #(.ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en_a  (dec_en_a),
    .en_b  (dec_en_b),
    .addr  (bus_addr),
    .wr    (bus_wr),
    .rd    (bus_rd),
    .rdata (bus_rdata),
    .start (start_pulse),
    .idx   (blk_idx)
);

// File: tb/smb_host_regs_test.sv
module smb_host_regs_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_en_a = 1'b0;
    logic       dec_en_b = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       start_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    smb_host_regs uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec_en_a    (dec_en_a),
        .dec_en_b    (dec_en_b),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .start_pulse (start_pulse)
    );

    typedef struct packed {
        logic       is_wr;
        logic [3:0] ofs;
        logic [7:0] dat;
        logic [7:0] exp;
    } vec_t;

    localparam int NVEC = 24;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 4'h0, 8'h00, 8'h00},  // R6 status reads zero
        '{1'b1, 4'h3, 8'hA5, 8'h00},
        '{1'b0, 4'h3, 8'h00, 8'hA5},  // R1
        '{1'b1, 4'h4, 8'h3C, 8'h00},
        '{1'b0, 4'h4, 8'h00, 8'h3C},  // R1
        '{1'b1, 4'h5, 8'h11, 8'h00},
        '{1'b0, 4'h5, 8'h00, 8'h11},  // R1
        '{1'b1, 4'h6, 8'h22, 8'h00},
        '{1'b0, 4'h6, 8'h00, 8'h22},  // R1
        '{1'b1, 4'h2, 8'hFF, 8'h00},
        '{1'b0, 4'h2, 8'h00, 8'h1F},  // R2 masked
        '{1'b1, 4'h7, 8'hD0, 8'h00},
        '{1'b1, 4'h7, 8'hD1, 8'h00},
        '{1'b1, 4'h7, 8'hD2, 8'h00},
        '{1'b0, 4'h2, 8'h00, 8'h1F},  // R2 rewind
        '{1'b0, 4'h7, 8'h00, 8'hD0},  // R4
        '{1'b0, 4'h7, 8'h00, 8'hD1},  // R4
        '{1'b0, 4'h7, 8'h00, 8'hD2},  // R4
        '{1'b0, 4'h7, 8'h00, 8'h00},  // R4 untouched entry
        '{1'b0, 4'h1, 8'h00, 8'h00},  // R8
        '{1'b0, 4'hA, 8'h00, 8'h00},  // R8
        '{1'b1, 4'hF, 8'h55, 8'h00},
        '{1'b0, 4'hF, 8'h00, 8'h00},  // R8
        '{1'b0, 4'h3, 8'h00, 8'hA5}   // R8 write to 0xF left command alone
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        do_reset();
        dec_en_a = 1'b1;

        // R9 reset state
        check("R9 start", {7'b0, start_pulse}, 8'h00);
        for (int a = 0; a < 8; a++) begin
            do_rd(4'(a), r);
            check("R9 reg", r, 8'h00);
        end

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].is_wr) begin
                do_wr(VECS[i].ofs, VECS[i].dat);
            end else begin
                do_rd(VECS[i].ofs, r);
                check($sformatf("R1/R2/R4/R6/R8 vec%0d", i), r, VECS[i].exp);
            end
        end

        // R3 start pulse timing
        @(negedge clk);
        bus_addr = 4'h2; bus_wdata = 8'h05; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
        check("R3 pulse high", {7'b0, start_pulse}, 8'h01);
        @(posedge clk);
        #1 check("R3 pulse low", {7'b0, start_pulse}, 8'h00);

        // R6 status write rewinds, R4/R5 fill and wrap
        do_wr(4'h0, 8'hFF);
        for (int k = 0; k < 32; k++) do_wr(4'h7, 8'(k * 3 + 1));
        do_wr(4'h7, 8'hEE);               // wraps to entry 0
        do_wr(4'h0, 8'h00);               // R6 rewind
        do_rd(4'h7, r);
        check("R5 write wrap", r, 8'hEE);
        do_rd(4'h7, r);
        check("R6 rewind entry1", r, 8'h04);
        do_rd(4'h0, r);
        check("R6 status zero", r, 8'h00);
        do_rd(4'h2, r);                   // R2 rewind by read
        for (int k = 0; k < 31; k++) do_rd(4'h7, r);
        check("R4 entry31", r, 8'(30 * 3 + 1));
        do_rd(4'h7, r);
        check("R4 last entry", r, 8'(31 * 3 + 1));
        do_rd(4'h7, r);
        check("R5 read wrap", r, 8'hEE);

        // R7 disabled access
        do_rd(4'h2, r);                   // rewind; index 0
        do_rd(4'h7, r);                   // index 1
        dec_en_a = 1'b0;
        do_rd(4'h3, r);
        check("R7 read ones", r, 8'hFF);
        do_wr(4'h3, 8'h77);
        do_rd(4'h2, r);                   // must not rewind
        do_rd(4'h7, r);                   // must not advance
        do_wr(4'h7, 8'h99);               // must not store
        @(negedge clk);
        bus_addr = 4'h2; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
        check("R7 no pulse", {7'b0, start_pulse}, 8'h00);
        dec_en_b = 1'b1;                  // second enable alone
        do_rd(4'h3, r);
        check("R7 cmd kept", r, 8'hA5);
        do_rd(4'h7, r);
        check("R7 index kept", r, 8'h04);
        do_rd(4'h2, r);
        check("R7 ctrl kept", r, 8'h05);
        dec_en_b = 1'b0;
        dec_en_a = 1'b1;

        // R9 reset mid-run
        do_reset();
        do_rd(4'h3, r);
        check("R9 cmd cleared", r, 8'h00);
        do_rd(4'h6, r);
        check("R9 data1 cleared", r, 8'h00);
        do_rd(4'h7, r);
        check("R9 buffer cleared", r, 8'h00);
        do_rd(4'h7, r);
        check("R9 buffer cleared 1", r, 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule